// File: doc/BRIEF.md
# UART Receiver with Line Status

This block turns an asynchronous serial input into parallel characters. It uses an oversampling tick that a baud generator outside the block supplies. The character format is set by live configuration inputs: a word length of five to eight bits, an optional parity bit and a choice of parity mode. These are the same settings the companion transmitter uses. Each received character goes into a single holding register. An eight-bit line status byte reports whether a character is waiting and what went wrong while it was being received.

The host reads the character with one strobe and the status byte with another. Each read clears its own group of flags. Two status bits are not produced here: the transmitter supplies them and they pass straight through, so the host sees one complete status byte. Multi-entry buffering, baud generation and interrupt generation belong to other blocks.

Top module: `uart_rx_lsr`

## Requirements
- R1: After a frame completes, `data_o` holds the received bits, first-received bit in bit 0 and unused upper bits zero, and status bit 0 (data ready) is set. Data ready never rises without a completed frame.
- R2: If a frame completes while data ready is still set and no data read happens in that cycle, the new word replaces the held word and status bit 1 (overrun) is set.
- R3: When `par_en_i` is 1, a parity bit follows the data. The expected value is the inverse of `par_even_i` when `par_stick_i` is 1. Otherwise it makes the count of ones across data and parity even (`par_even_i`=1) or odd (`par_even_i`=0). A mismatch sets status bit 2.
- R4: `wlen_i` selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3.
- R5: If the stop-bit sample is 0, status bit 3 (framing error) is set.
- R6: Status bit 7 is 1 while the held word was received with a parity, framing or break error. A data read clears it, and a clean word replaces it with 0.
- R7: A frame sampled as all zeros, stop bit included, sets status bits 4 (break) and 3 and stores a zero word. Only one word is stored per break. No new start is searched for until the line returns to 1.
- R8: A falling edge starts a frame only if the line is still low at the mid-point of the start bit. Shorter low pulses store nothing.
- R9: A data read clears data ready unless a frame completes in the same cycle. A status read clears bits 1 to 4, except a flag set in that same cycle.
- R10: Status bit 6 follows `tx_empty_i` and bit 5 follows `tx_hold_empty_i`.
- R11: After reset, the data register and status bits 0 to 4 and 7 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| os_tick_i | input | 1 | Oversampling enable, OSR pulses per bit time |
| rxd_i | input | 1 | Serial input, idle high |
| wlen_i | input | 2 | Word length code (0..3 = 5..8 bits) |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | Even parity select |
| par_stick_i | input | 1 | Stick parity select |
| tx_empty_i | input | 1 | Transmitter fully idle, shown in status bit 6 |
| tx_hold_empty_i | input | 1 | Transmit holding register free, shown in status bit 5 |
| data_rd_i | input | 1 | Data read strobe |
| status_rd_i | input | 1 | Status read strobe |
| data_o | output | 8 | Held received word |
| status_o | output | 8 | Line status byte |

## Verification
The bench builds the block with OSR=8 and two synchronizer stages, and holds the oversampling tick high. One bit then lasts eight clocks. Frames stay short enough that overrun, the long breaks needed for the single-word check, and runt start pulses of two clocks all fit in a short run. With the small OSR, a runt pulse shorter than half a bit is still a whole number of clocks, so the start-validation rule can be tested exactly.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned IDX_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
  } rx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } line_cfg_t;

  typedef struct packed {
    logic perr;
    logic ferr;
    logic brk;
  } word_err_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  line_cfg_t         cfg_i,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o,
  output word_err_t         err_o
);
  localparam int unsigned CW = $clog2(OSR);
  localparam logic [CW-1:0] MID_C  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              acc_q, par_q, zero_q, done_q;
  word_err_t         err_q;

  logic [IDX_W-1:0]  last_idx;
  logic              exp_par, sample, brk_now;

  assign last_idx = IDX_W'(4) + IDX_W'(cfg_i.wlen);
  assign exp_par  = cfg_i.par_stick ? ~cfg_i.par_even
                  : (cfg_i.par_even ? acc_q : ~acc_q);
  assign sample   = tick_i && (cnt_q == LAST_C);
  assign brk_now  = zero_q & ~rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      acc_q   <= 1'b0;
      par_q   <= 1'b0;
      zero_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (tick_i && state_q != ST_IDLE && state_q != ST_HOLD && !sample &&
          !(state_q == ST_START && cnt_q == MID_C))
        cnt_q <= cnt_q + 1'b1;
      case (state_q)
        ST_IDLE: if (tick_i && !rx_i) begin
          state_q <= ST_START;
          cnt_q   <= '0;
        end
        ST_START: if (tick_i && cnt_q == MID_C) begin
          if (!rx_i) begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            acc_q   <= 1'b0;
            zero_q  <= 1'b1;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_DATA: if (sample) begin
          cnt_q          <= '0;
          shreg_q[idx_q] <= rx_i;
          acc_q          <= acc_q ^ rx_i;
          zero_q         <= zero_q & ~rx_i;
          idx_q          <= idx_q + 1'b1;
          if (idx_q == last_idx) state_q <= cfg_i.par_en ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (sample) begin
          cnt_q   <= '0;
          par_q   <= rx_i;
          zero_q  <= zero_q & ~rx_i;
          state_q <= ST_STOP;
        end
        ST_STOP: if (sample) begin
          cnt_q      <= '0;
          done_q     <= 1'b1;
          err_q.ferr <= ~rx_i;
          err_q.brk  <= brk_now;
          err_q.perr <= cfg_i.par_en & ~brk_now & (par_q != exp_par);
          state_q    <= rx_i ? ST_IDLE : ST_HOLD;
        end
        ST_HOLD: if (rx_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign word_o = shreg_q;
  assign err_o  = err_q;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] word_i,
  input  word_err_t         err_i,
  input  logic              data_rd_i,
  input  logic              status_rd_i,
  input  logic              tx_empty_i,
  input  logic              tx_hold_empty_i,
  output logic [DATA_W-1:0] data_o,
  output logic [7:0]        status_o
);
  logic [DATA_W-1:0] hold_q;
  logic dr_q, oe_q, pe_q, fe_q, bi_q, herr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      dr_q   <= 1'b0;
      oe_q   <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      bi_q   <= 1'b0;
      herr_q <= 1'b0;
    end else begin
      if (done_i) begin
        hold_q <= word_i;
        herr_q <= err_i.perr | err_i.ferr | err_i.brk;
      end else if (data_rd_i) begin
        herr_q <= 1'b0;
      end

      if (done_i)         dr_q <= 1'b1;
      else if (data_rd_i) dr_q <= 1'b0;

      if (done_i && dr_q && !data_rd_i) oe_q <= 1'b1;
      else if (status_rd_i)             oe_q <= 1'b0;

      if (done_i && err_i.perr) pe_q <= 1'b1;
      else if (status_rd_i)     pe_q <= 1'b0;

      if (done_i && err_i.ferr) fe_q <= 1'b1;
      else if (status_rd_i)     fe_q <= 1'b0;

      if (done_i && err_i.brk)  bi_q <= 1'b1;
      else if (status_rd_i)     bi_q <= 1'b0;
    end
  end

  assign data_o   = hold_q;
  assign status_o = {herr_q, tx_empty_i, tx_hold_empty_i, bi_q, fe_q, pe_q, oe_q, dr_q};
endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       os_tick_i,
  input  logic       rxd_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       par_stick_i,
  input  logic       tx_empty_i,
  input  logic       tx_hold_empty_i,
  input  logic       data_rd_i,
  input  logic       status_rd_i,
  output logic [7:0] data_o,
  output logic [7:0] status_o
);
  logic              rx_s;
  logic              word_done;
  logic [DATA_W-1:0] word;
  word_err_t         word_err;
  line_cfg_t         cfg;

  assign cfg = '{wlen: wlen_i, par_en: par_en_i, par_even: par_even_i,
                 par_stick: par_stick_i};

  uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  uart_rx_frame #(.OSR(OSR)) i_frame (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(os_tick_i),
    .rx_i  (rx_s),
    .cfg_i (cfg),
    .done_o(word_done),
    .word_o(word),
    .err_o (word_err)
  );

  uart_rx_status i_status (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .done_i         (word_done),
    .word_i         (word),
    .err_i          (word_err),
    .data_rd_i      (data_rd_i),
    .status_rd_i    (status_rd_i),
    .tx_empty_i     (tx_empty_i),
    .tx_hold_empty_i(tx_hold_empty_i),
    .data_o         (data_o),
    .status_o       (status_o)
  );
endmodule

// File: rtl/uart_rx_lsr_chk.sv
module uart_rx_lsr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       word_done,
  input logic       data_rd_i,
  input logic       status_rd_i,
  input logic [4:0] lsr_lo,
  input logic       held_err
);
  a_r1_ready_after_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done |=> lsr_lo[0]);

  a_r1_ready_needs_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lsr_lo[0]) |-> $past(word_done));

  a_r2_overrun_on_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done && lsr_lo[0] && !data_rd_i) |=> lsr_lo[1]);

  a_r9_data_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && !word_done) |=> !lsr_lo[0]);

  a_r9_status_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && !word_done) |=> (lsr_lo[4:1] == 4'b0000));

  a_r6_err_with_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_err |-> lsr_lo[0]);

  a_r7_break_frames: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_lo[4] |-> lsr_lo[3]);
endmodule

bind uart_rx_lsr uart_rx_lsr_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .word_done  (word_done),
  .data_rd_i  (data_rd_i),
  .status_rd_i(status_rd_i),
  .lsr_lo     (status_o[4:0]),
  .held_err   (status_o[7])
);

// File: tb/test_uart_rx_lsr.sv
module test_uart_rx_lsr;
  localparam int OSR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic [1:0] wlen = 2'd3;
  logic par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic tx_empty = 1'b1, tx_hold_empty = 1'b1;
  logic data_rd = 1'b0, status_rd = 1'b0;
  logic [7:0] data, status;

  int n_checks = 0;
  int n_err = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  uart_rx_lsr #(.OSR(OSR), .SYNC_STAGES(2)) i_uart_rx_lsr (
    .clk_i(clk), .rst_ni(rst_n), .os_tick_i(1'b1), .rxd_i(rxd),
    .wlen_i(wlen), .par_en_i(par_en), .par_even_i(par_even),
    .par_stick_i(par_stick), .tx_empty_i(tx_empty),
    .tx_hold_empty_i(tx_hold_empty), .data_rd_i(data_rd),
    .status_rd_i(status_rd), .data_o(data), .status_o(status)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act=%02h exp=%02h", req, act, exp);
    end
  endtask

  function automatic logic par_bit(input logic [7:0] d, input int nb,
                                   input logic even, input logic stick);
    logic x = 1'b0;
    for (int i = 0; i < nb; i++) x ^= d[i];
    if (stick) return ~even;
    return even ? x : ~x;
  endfunction

  task automatic line_bit(input logic v);
    rxd = v;
    repeat (OSR) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input logic pen,
                      input logic pb, input logic stopv);
    @(negedge clk);
    line_bit(1'b0);
    for (int i = 0; i < nb; i++) line_bit(d[i]);
    if (pen) line_bit(pb);
    line_bit(stopv);
    rxd = 1'b1;
    repeat (2*OSR) @(negedge clk);
  endtask

  task automatic rd_data();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic rd_status();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask

  task automatic clear_all();
    rd_data();
    rd_status();
  endtask

  task automatic t_reset();
    chk("R11 reset status", status, 8'h60);
    chk("R11 reset data", data, 8'h00);
  endtask

  task automatic t_basic();
    wlen = 2'd3; par_en = 1'b0;
    send(8'hA5, 8, 1'b0, 1'b0, 1'b1);
    chk("R1 data", data, 8'hA5);
    chk("R1 status", status, 8'h61);
    rd_data();
    chk("R9 data read clears ready", status, 8'h60);
  endtask

  task automatic t_overrun();
    send(8'h11, 8, 1'b0, 1'b0, 1'b1);
    send(8'h22, 8, 1'b0, 1'b0, 1'b1);
    chk("R2 newest word kept", data, 8'h22);
    chk("R2 overrun set", status, 8'h63);
    rd_status();
    chk("R9 status read clears overrun", status, 8'h61);
    rd_data();
  endtask

  task automatic t_parity();
    wlen = 2'd2; par_en = 1'b1; par_even = 1'b1; par_stick = 1'b0;
    send(8'h35, 7, 1'b1, par_bit(8'h35, 7, 1'b1, 1'b0), 1'b1);
    chk("R3 even parity ok data", data, 8'h35);
    chk("R3 even parity ok status", status, 8'h61);
    rd_data();
    send(8'h35, 7, 1'b1, ~par_bit(8'h35, 7, 1'b1, 1'b0), 1'b1);
    chk("R3 parity error", status, 8'hE5);
    rd_data();
    chk("R6 held error clears on data read", status, 8'h64);
    rd_status();
    chk("R9 status read clears parity", status, 8'h60);
    par_stick = 1'b1;
    wlen = 2'd3;
    send(8'hC3, 8, 1'b1, 1'b0, 1'b1);
    chk("R3 stick parity ok", status, 8'h61);
    rd_data();
    send(8'hC3, 8, 1'b1, 1'b1, 1'b1);
    chk("R3 stick parity bad", status, 8'hE5);
    clear_all();
    par_stick = 1'b0;
  endtask

  task automatic t_wlen();
    wlen = 2'd0; par_en = 1'b1; par_even = 1'b0;
    send(8'hF5, 5, 1'b1, par_bit(8'hF5, 5, 1'b0, 1'b0), 1'b1);
    chk("R4 five bits odd parity data", data, 8'h15);
    chk("R4 five bits status", status, 8'h61);
    rd_data();
    wlen = 2'd1; par_en = 1'b0;
    send(8'hEA, 6, 1'b0, 1'b0, 1'b1);
    chk("R4 six bits data", data, 8'h2A);
    chk("R6 clean word no error", status, 8'h61);
    clear_all();
    wlen = 2'd3;
  endtask

  task automatic t_framing();
    send(8'h5A, 8, 1'b0, 1'b0, 1'b0);
    chk("R5 framing data", data, 8'h5A);
    chk("R5 framing status", status, 8'hE9);
    clear_all();
    chk("R9 flags cleared", status, 8'h60);
  endtask

  task automatic t_break();
    @(negedge clk);
    rxd = 1'b0;
    repeat (30*OSR) @(negedge clk);
    rxd = 1'b1;
    repeat (3*OSR) @(negedge clk);
    chk("R7 break single word status", status, 8'hF9);
    chk("R7 break data zero", data, 8'h00);
    clear_all();
    send(8'h3C, 8, 1'b0, 1'b0, 1'b1);
    chk("R7 receive resumes after break", data, 8'h3C);
    clear_all();
  endtask

  task automatic t_runt();
    @(negedge clk);
    rxd = 1'b0;
    repeat (OSR/2 - 2) @(negedge clk);
    rxd = 1'b1;
    repeat (12*OSR) @(negedge clk);
    chk("R8 runt pulse ignored", status, 8'h60);
  endtask

  task automatic t_tx_bits();
    tx_empty = 1'b0; tx_hold_empty = 1'b1;
    @(negedge clk);
    chk("R10 tx empty low", status, 8'h20);
    tx_hold_empty = 1'b0;
    @(negedge clk);
    chk("R10 both low", status, 8'h00);
    tx_empty = 1'b1; tx_hold_empty = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_basic();
    t_overrun();
    t_parity();
    t_wlen();
    t_framing();
    t_break();
    t_runt();
    t_tx_bits();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule